// File: doc/BRIEF.md
# Dual-Source Serial Test Word Transmitter

The block produces a continuous stream of 24-bit test words on a serial line. Each frame takes its word from one of two parallel sources, a diagnostic word and a verification word, selected by a mode input at the moment the word is captured. A small sequencer paces the frame on a single-cycle bit-rate enable. The first step captures the word into a shift register and clears the counters. The second step is a setup step. Each later step sends one bit, most significant first. After the last bit the frame starts again at the capture step.

The serial bit leaves on a true output and a complement output. A gated clock output pulses once per transmitted bit, in the same cycle as the bit-rate enable. A strobe marks the capture step and stays low while bits are being sent. A byte counter raises a terminal flag after every eighth counted bit. A toggle stage, clocked by the falling edge of that flag, drives a downstream gate output.

Top module: `test_word_tx`

## Requirements
- R1: On the capture step the register loads `verif_word_i` when `mode_sel_i` is 1 and `diag_word_i` when it is 0.
- R2: A frame is exactly 26 bit-rate steps: one capture step, one setup step, then 24 transmit steps. After the last transmit step the next step is a capture step.
- R3: Bits leave most significant first. Bit 23-k is on `ser_data_o` during the k-th transmit step. After all 24 bits, `ser_data_o` is 0 until the next frame begins.
- R4: `ser_data_n_o` is always the complement of `ser_data_o`.
- R5: `ser_clk_o` is high only in a transmit step and only in the cycle where `bit_en_i` is high. It is low in capture and setup steps.
- R6: `strobe_o` is high during the capture phase and low during setup and transmit. It rises only in the cycle after the last transmit pulse.
- R7: While `bit_en_i` stays low, the sequence does not advance and the outputs hold.
- R8: `byte_tc_o` is high once 8, 16 or 24 bits of the current frame have been counted, until the next count or the next capture step.
- R9: `byte_gate_o` is 1 after reset. It inverts on the clock edge after each falling edge of `byte_tc_o`.
- R10: While `rst_ni` is low the block is in the capture phase, with `ser_data_o`=0, `ser_data_n_o`=1, `ser_clk_o`=0, `strobe_o`=1, `byte_tc_o`=0 and `byte_gate_o`=1.
- R11: Changes on `mode_sel_i`, `diag_word_i` or `verif_word_i` after the capture step do not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle bit-rate step enable |
| mode_sel_i | input | 1 | Source select: 1 selects the verification word, 0 the diagnostic word |
| diag_word_i | input | 24 | Diagnostic source word |
| verif_word_i | input | 24 | Verification source word |
| ser_data_o | output | 1 | Serial data, true |
| ser_data_n_o | output | 1 | Serial data, complement |
| ser_clk_o | output | 1 | Gated bit clock, one pulse per sent bit |
| strobe_o | output | 1 | Capture-phase strobe |
| byte_tc_o | output | 1 | Byte terminal count flag |
| byte_gate_o | output | 1 | Gate driven by the byte toggle stage |

## Verification
The checker watches these properties on every cycle:
- the complementary pair;
- that a clock pulse comes only with the bit-rate enable and never during the strobe;
- that outputs hold while the enable is low;
- that the strobe rises only right after a transmit pulse;
- that the gate output moves only after the byte flag falls.

Only the bench's scenarios can show the rest:
- that the right source is chosen;
- bit order and the 26-step frame length;
- where the byte flag sits;
- that late source changes are ignored;
- that reset in mid-frame restarts cleanly.

The bench shows these by following whole frames against words and modes it knows.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_ARM  = 2'd1,
    PH_RUN  = 2'd2
  } tx_phase_e;
endpackage

// File: rtl/tx_src_mux.sv
module tx_src_mux #(
  parameter int WORD_W = 24
) (
  input  logic              sel_i,
  input  logic [WORD_W-1:0] diag_i,
  input  logic [WORD_W-1:0] verif_i,
  output logic [WORD_W-1:0] word_o
);
  assign word_o = sel_i ? verif_i : diag_i;
endmodule

// File: rtl/tx_seq.sv
module tx_seq
  import tx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bit_en_i,
  output tx_phase_e phase_o,
  output logic      load_o,
  output logic      shift_o,
  output logic      byte_tc_o
);
  localparam int BIT_CW  = $clog2(WORD_W + 1);
  localparam int BYTE_CW = $clog2(BYTE_W + 1);
  localparam logic [BIT_CW-1:0]  LAST_BIT = BIT_CW'(WORD_W - 1);
  localparam logic [BYTE_CW-1:0] BYTE_TOP = BYTE_CW'(BYTE_W);

  tx_phase_e           phase_q;
  logic [BIT_CW-1:0]   bit_cnt_q;
  logic [BYTE_CW-1:0]  byte_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_LOAD;
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
    end else if (bit_en_i) begin
      unique case (phase_q)
        PH_LOAD: begin
          bit_cnt_q  <= '0;
          byte_cnt_q <= '0;
          phase_q    <= PH_ARM;
        end
        PH_ARM: phase_q <= PH_RUN;
        PH_RUN: begin
          bit_cnt_q  <= bit_cnt_q + 1'b1;
          byte_cnt_q <= (byte_cnt_q == BYTE_TOP) ? BYTE_CW'(1) : byte_cnt_q + 1'b1;
          if (bit_cnt_q == LAST_BIT) phase_q <= PH_LOAD;
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign load_o    = bit_en_i && (phase_q == PH_LOAD);
  assign shift_o   = bit_en_i && (phase_q == PH_RUN);
  assign byte_tc_o = (byte_cnt_q == BYTE_TOP);
endmodule

// File: rtl/tx_shreg.sv
module tx_shreg #(
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] par_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= par_i;
    else if (shift_i) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end

  assign msb_o = sh_q[WORD_W-1];
endmodule

// File: rtl/tx_toggle.sv
module tx_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tc_i,
  output logic gate_o
);
  logic tc_q, gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q   <= 1'b0;
      gate_q <= 1'b1;
    end else begin
      tc_q <= tc_i;
      if (tc_q && !tc_i) gate_q <= ~gate_q;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/test_word_tx.sv
module test_word_tx
  import tx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              mode_sel_i,
  input  logic [WORD_W-1:0] diag_word_i,
  input  logic [WORD_W-1:0] verif_word_i,
  output logic              ser_data_o,
  output logic              ser_data_n_o,
  output logic              ser_clk_o,
  output logic              strobe_o,
  output logic              byte_tc_o,
  output logic              byte_gate_o
);
  logic [WORD_W-1:0] src_word;
  tx_phase_e         phase;
  logic              load, shift, msb;

  tx_src_mux #(.WORD_W(WORD_W)) u_mux (
    .sel_i   (mode_sel_i),
    .diag_i  (diag_word_i),
    .verif_i (verif_word_i),
    .word_o  (src_word)
  );

  tx_seq #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .phase_o   (phase),
    .load_o    (load),
    .shift_o   (shift),
    .byte_tc_o (byte_tc_o)
  );

  tx_shreg #(.WORD_W(WORD_W)) u_sh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .par_i   (src_word),
    .msb_o   (msb)
  );

  tx_toggle u_tog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tc_i   (byte_tc_o),
    .gate_o (byte_gate_o)
  );

  assign ser_data_o   = msb;
  assign ser_data_n_o = ~msb;
  assign ser_clk_o    = shift;
  assign strobe_o     = (phase == PH_LOAD);
endmodule

// File: rtl/test_word_tx_chk.sv
module test_word_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic ser_data_o,
  input logic ser_data_n_o,
  input logic ser_clk_o,
  input logic strobe_o,
  input logic byte_tc_o,
  input logic byte_gate_o
);
  // R4
  pair_compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_data_n_o == !ser_data_o);

  // R5
  clk_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_clk_o |-> (bit_en_i && !strobe_o));

  // R7
  hold_no_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(ser_data_o) && $stable(strobe_o) && $stable(byte_tc_o)));

  // R6
  strobe_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_o) |-> $past(ser_clk_o));

  // R9
  gate_on_tc_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(byte_gate_o) |-> ($past(byte_tc_o, 2) && !$past(byte_tc_o)));
endmodule

bind test_word_tx test_word_tx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_en_i     (bit_en_i),
  .ser_data_o   (ser_data_o),
  .ser_data_n_o (ser_data_n_o),
  .ser_clk_o    (ser_clk_o),
  .strobe_o     (strobe_o),
  .byte_tc_o    (byte_tc_o),
  .byte_gate_o  (byte_gate_o)
);

// File: tb/tb_test_word_tx.sv
module tb_test_word_tx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en = 1'b0;
  logic        mode_sel = 1'b0;
  logic [23:0] diag = '0;
  logic [23:0] verif = '0;
  logic        sd, sdn, sclk, strb, tc, gate;

  int n_chk = 0;
  int n_bad = 0;
  int bits_prev = 0;
  logic exp_gate = 1'b1;

  always #5 clk = ~clk;

  test_word_tx dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en),
    .mode_sel_i   (mode_sel),
    .diag_word_i  (diag),
    .verif_word_i (verif),
    .ser_data_o   (sd),
    .ser_data_n_o (sdn),
    .ser_clk_o    (sclk),
    .strobe_o     (strb),
    .byte_tc_o    (tc),
    .byte_gate_o  (gate)
  );

  // {mode, diag, verif, expected word}
  localparam logic [72:0] VECS [4] = '{
    {1'b0, 24'hA5C3_81, 24'h0F0F_0F, 24'hA5C3_81},
    {1'b1, 24'hA5C3_81, 24'h0F0F_0F, 24'h0F0F_0F},
    {1'b1, 24'h000000,  24'hFFFF_FF, 24'hFFFF_FF},
    {1'b0, 24'h800001,  24'h7FFF_FE, 24'h800001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one bit-rate step; outputs sampled while bit_en is high, before the edge
  task automatic step();
    @(negedge clk);
    bit_en = 1'b1;
    #1;
  endtask

  task automatic step_end();
    @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_gate(input string req);
    #1 chk(req, {31'd0, gate}, {31'd0, exp_gate});
  endtask

  task automatic run_frame(input logic m, input logic [23:0] dw, input logic [23:0] vw,
                           input logic [23:0] ex);
    logic held;
    mode_sel = m; diag = dw; verif = vw;
    // capture step
    step();
    chk("R6 strobe in capture", {31'd0, strb}, 32'd1);
    chk("R5 no clock in capture", {31'd0, sclk}, 32'd0);
    chk("R3 idle data in capture", {31'd0, sd}, 32'd0);
    chk("R4 pair in capture", {31'd0, sdn}, {31'd0, ~sd});
    chk("R8 tc in capture", {31'd0, tc}, {31'd0, bits_prev == 24});
    step_end();
    if (bits_prev == 24) exp_gate = ~exp_gate;
    check_gate("R9 gate after capture");
    // R11: disturb sources after capture
    mode_sel = ~m; diag = ~dw; verif = ~vw;
    // setup step
    step();
    chk("R6 strobe low in setup", {31'd0, strb}, 32'd0);
    chk("R5 no clock in setup", {31'd0, sclk}, 32'd0);
    chk("R1 source word msb", {31'd0, sd}, {31'd0, ex[23]});
    chk("R8 tc clear in setup", {31'd0, tc}, 32'd0);
    step_end();
    for (int k = 0; k < 24; k++) begin
      if (k == 5) begin
        held = sd;
        repeat (7) @(negedge clk);
        chk("R7 data held without enable", {31'd0, sd}, {31'd0, held});
        chk("R7 no clock without enable", {31'd0, sclk}, 32'd0);
        chk("R7 strobe held without enable", {31'd0, strb}, 32'd0);
      end
      step();
      chk("R3 R11 bit value", {31'd0, sd}, {31'd0, ex[23-k]});
      chk("R4 pair in shift", {31'd0, sdn}, {31'd0, ~ex[23-k]});
      chk("R5 clock pulse per bit", {31'd0, sclk}, 32'd1);
      chk("R6 strobe low in shift", {31'd0, strb}, 32'd0);
      chk("R8 tc before bit", {31'd0, tc}, {31'd0, (k > 0) && (k % 8 == 0)});
      step_end();
      if (k == 8 || k == 16) exp_gate = ~exp_gate;
      check_gate("R9 gate in shift");
    end
    chk("R2 capture phase after 24 bits", {31'd0, strb}, 32'd1);
    chk("R8 tc after 24th bit", {31'd0, tc}, 32'd1);
    chk("R3 line idle after frame", {31'd0, sd}, 32'd0);
    bits_prev = 24;
  endtask

  task automatic check_reset(input string tag);
    chk({tag, " R10 data"}, {31'd0, sd}, 32'd0);
    chk({tag, " R10 data_n"}, {31'd0, sdn}, 32'd1);
    chk({tag, " R10 clock"}, {31'd0, sclk}, 32'd0);
    chk({tag, " R10 strobe"}, {31'd0, strb}, 32'd1);
    chk({tag, " R10 tc"}, {31'd0, tc}, 32'd0);
    chk({tag, " R10 gate"}, {31'd0, gate}, 32'd1);
  endtask

  initial begin
    #100_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset("initial");
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 4; i++)
      run_frame(VECS[i][72], VECS[i][71:48], VECS[i][47:24], VECS[i][23:0]);

    // reset in mid-frame
    mode_sel = 1'b1; verif = 24'h5A5A5A;
    for (int i = 0; i < 12; i++) begin
      step();
      step_end();
    end
    rst_ni = 1'b0;
    #1;
    check_reset("mid-frame");
    @(negedge clk);
    rst_ni = 1'b1;
    exp_gate = 1'b1;
    bits_prev = 0;
    run_frame(1'b0, 24'hC0FFEE, 24'h123456, 24'hC0FFEE);
    run_frame(1'b1, 24'hC0FFEE, 24'h123456, 24'h123456);

    summary();
  end
endmodule